// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block decides which interrupt an 8051-style core takes next, and it tracks how deeply the core is nested in service routines. It takes up to six request sources, an enable register and two priority registers. The core raises a strobe at each instruction boundary. On that strobe the controller picks the pending enabled source with the highest two-bit priority. It accepts the source only when that priority is strictly above every level already in service. When it accepts, it registers a one-cycle take pulse, the source index and the entry address, and it records the new level in a four-bit in-service mask. A return pulse from the core removes the level that is running now. Service then falls back to the highest level still recorded.

The core uses the take pulse to push its program counter, jump to the entry address and add two machine cycles to the current instruction. It uses the acknowledged index to clear the timer flags. The controller raises its own clear pulse for external request 0 only when that input is set to edge mode. The serial flags are never cleared here.

The in-service tracker is a two-state machine. `ST_IDLE` means no level is in service. `ST_NESTED` means at least one level is. The transitions are:
- `T_ENTER`: from `ST_IDLE` to `ST_NESTED` on an acceptance.
- `T_DEEPEN`: from `ST_NESTED` to `ST_NESTED` on a preempting acceptance.
- `T_UNWIND`: from `ST_NESTED` to `ST_NESTED` on a return that leaves levels behind.
- `T_LEAVE`: from `ST_NESTED` to `ST_IDLE` on a return that empties the mask.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, take_o is 0, active_o is 0, cur_valid_o is 0, and both priority registers are 0, so every source sits at level 0.
- R2: While ie_i[7] (global enable) is 0, no request is accepted.
- R3: Source indices are 0 = ext0_flag_i, 1 = t0_ovf_i, 2 = ext1_flag_i, 3 = t1_ovf_i, 4 = serial, 5 = timer 2. ie_i[i] enables source i, and a source whose enable bit is 0 is never accepted.
- R4: The priority of source i is {hi[i], lo[i]}, where hi is written through phi_we_i and lo through plo_we_i, each from wdata_i. The highest pending priority wins.
- R5: When priorities are equal, the lowest source index wins.
- R6: vector_o equals source index × 8 + 3 (0x03, 0x0B, 0x13, 0x1B, 0x23, 0x2B).
- R7: A winner is accepted only when no level is in service or its priority is strictly greater than cur_lvl_o. A winner at an equal or lower priority is held off.
- R8: An acceptance sets take_o for one cycle in the cycle after the boundary strobe, together with ack_src_o and vector_o. It also sets bit p of active_o, where p is the accepted priority, and cur_lvl_o becomes p.
- R9: reti_i clears the active_o bit of the current level. cur_lvl_o then becomes the highest remaining set bit, and cur_valid_o drops if none remain. A return with no level active changes nothing. No acceptance happens in a cycle where reti_i is high.
- R10: When source 0 is accepted, clr_ext0_o pulses together with take_o only if ext0_edge_i is 1.
- R11: Source 4 requests when ser_rx_i OR ser_tx_i is set. Source 5 requests when t2_ovf_i OR t2_ext_i is set, and only when HAS_T2 = 1.
- R12: Requests are evaluated only in cycles where boundary_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction boundary strobe |
| reti_i | input | 1 | Return-from-interrupt pulse |
| ext0_flag_i | input | 1 | External request 0 flag |
| ext0_edge_i | input | 1 | External 0 is edge-triggered |
| t0_ovf_i | input | 1 | Timer 0 overflow flag |
| ext1_flag_i | input | 1 | External request 1 flag |
| t1_ovf_i | input | 1 | Timer 1 overflow flag |
| ser_rx_i | input | 1 | Serial receive flag |
| ser_tx_i | input | 1 | Serial transmit flag |
| t2_ovf_i | input | 1 | Timer 2 overflow flag |
| t2_ext_i | input | 1 | Timer 2 external flag |
| ie_i | input | 8 | Enable register; bit 7 global, bits 5..0 per source |
| plo_we_i | input | 1 | Write strobe, low priority bits |
| phi_we_i | input | 1 | Write strobe, high priority bits |
| wdata_i | input | 8 | Priority write data |
| take_o | output | 1 | Acceptance pulse |
| vector_o | output | 8 | Entry address of the accepted source |
| ack_src_o | output | 3 | Index of the accepted source |
| clr_ext0_o | output | 1 | Clear external 0 flag |
| active_o | output | 4 | In-service level mask |
| cur_valid_o | output | 1 | Some level is in service |
| cur_lvl_o | output | 2 | Current in-service level |

## Verification
The arbitration table applies one request pattern per entry, starting from reset each time.
- All-pending patterns at equal priority separate the lowest-index rule from a highest-index rule.
- Patterns that raise a higher-index source on only the low bit or only the high bit show whether the high bit really ranks above the low bit.
- Patterns with the global enable or single enables cleared show whether masking happens before selection.

A nesting walk then climbs through levels 0, 1 and 3, offers a lower and an equal request, and unwinds with returns. One return arrives on the same cycle as a boundary strobe. This shows whether the return picks the correct next level and whether it blocks acceptance.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
    localparam int MAX_SRC = 6;
    localparam int LVL_W   = 2;
    localparam int N_LVL   = 1 << LVL_W;
    localparam int IDX_W   = 3;
    localparam int VEC_W   = 8;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_NESTED = 1'b1
    } nest_state_e;

    function automatic logic [VEC_W-1:0] entry_addr(input logic [IDX_W-1:0] idx);
        return {2'b00, idx, 3'b011};
    endfunction
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_nest_pkg::*;
#(
    parameter int NSRC = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  plo_we,
    input  logic                  phi_we,
    input  logic [7:0]            wdata,
    output logic [NSRC-1:0][LVL_W-1:0] prio_o
);
    logic [7:0] plo_q;
    logic [7:0] phi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plo_q <= '0;
            phi_q <= '0;
        end else begin
            if (plo_we) plo_q <= wdata;
            if (phi_we) phi_q <= wdata;
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_map
        assign prio_o[g] = {phi_q[g], plo_q[g]};
    end

    logic unused_upper;
    assign unused_upper = ^{plo_q[7:NSRC], phi_q[7:NSRC]};
endmodule

// File: rtl/irq_winner_sel.sv
module irq_winner_sel
    import irq_nest_pkg::*;
#(
    parameter int NSRC = 6
) (
    input  logic [NSRC-1:0]            req,
    input  logic [NSRC-1:0][LVL_W-1:0] prio,
    output logic                       win_valid,
    output logic [IDX_W-1:0]           win_idx,
    output lvl_t                       win_prio
);
    // Ascending scan, replace only on strictly greater: ties keep lower index.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && (!win_valid || prio[i] > win_prio)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_prio  = prio[i];
            end
        end
    end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track
    import irq_nest_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  lvl_t             push_lvl,
    input  logic             pop,
    output logic [N_LVL-1:0] active,
    output logic             cur_valid,
    output lvl_t             cur_lvl
);
    nest_state_e     state_q, state_d;
    logic [N_LVL-1:0] mask_q, mask_d;

    // Highest set bit of the mask is the level in service.
    always_comb begin
        cur_lvl = '0;
        for (int i = 0; i < N_LVL; i++) begin
            if (mask_q[i]) cur_lvl = LVL_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
        end
    end

    always_comb begin
        state_d = state_q;
        mask_d  = mask_q;
        unique case (state_q)
            ST_IDLE: begin
                if (push) begin                       // T_ENTER
                    mask_d  = N_LVL'(1) << push_lvl;
                    state_d = ST_NESTED;
                end
            end
            ST_NESTED: begin
                if (push) begin                       // T_DEEPEN
                    mask_d = mask_q | (N_LVL'(1) << push_lvl);
                end else if (pop) begin
                    mask_d = mask_q & ~(N_LVL'(1) << cur_lvl);
                    if (mask_d == '0) state_d = ST_IDLE;  // T_LEAVE
                end                                        // else T_UNWIND
            end
            default: begin
                state_d = ST_IDLE;
                mask_d  = '0;
            end
        endcase
    end

    assign active    = mask_q;
    assign cur_valid = (state_q == ST_NESTED);
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter bit HAS_T2 = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        boundary_i,
    input  logic        reti_i,
    input  logic        ext0_flag_i,
    input  logic        ext0_edge_i,
    input  logic        t0_ovf_i,
    input  logic        ext1_flag_i,
    input  logic        t1_ovf_i,
    input  logic        ser_rx_i,
    input  logic        ser_tx_i,
    input  logic        t2_ovf_i,
    input  logic        t2_ext_i,
    input  logic [7:0]  ie_i,
    input  logic        plo_we_i,
    input  logic        phi_we_i,
    input  logic [7:0]  wdata_i,
    output logic        take_o,
    output logic [7:0]  vector_o,
    output logic [2:0]  ack_src_o,
    output logic        clr_ext0_o,
    output logic [3:0]  active_o,
    output logic        cur_valid_o,
    output logic [1:0]  cur_lvl_o
);
    localparam int NSRC = HAS_T2 ? MAX_SRC : MAX_SRC - 1;

    logic [NSRC-1:0]            raw_req;
    logic [NSRC-1:0]            en_req;
    logic [NSRC-1:0][LVL_W-1:0] prio;
    logic                       win_valid;
    logic [IDX_W-1:0]           win_idx;
    lvl_t                       win_prio;
    logic                       accept;
    logic [N_LVL-1:0]           active;
    logic                       cur_valid;
    lvl_t                       cur_lvl;

    assign raw_req[0] = ext0_flag_i;
    assign raw_req[1] = t0_ovf_i;
    assign raw_req[2] = ext1_flag_i;
    assign raw_req[3] = t1_ovf_i;
    assign raw_req[4] = ser_rx_i | ser_tx_i;

    if (HAS_T2) begin : g_t2
        assign raw_req[5] = t2_ovf_i | t2_ext_i;
        logic unused_ie;
        assign unused_ie = ie_i[6];
    end else begin : g_no_t2
        logic unused_t2;
        assign unused_t2 = ^{t2_ovf_i, t2_ext_i, ie_i[6:5]};
    end

    assign en_req = raw_req & ie_i[NSRC-1:0];

    irq_prio_regs #(.NSRC(NSRC)) u_prio (
        .clk    (clk),
        .rst_n  (rst_n),
        .plo_we (plo_we_i),
        .phi_we (phi_we_i),
        .wdata  (wdata_i),
        .prio_o (prio)
    );

    irq_winner_sel #(.NSRC(NSRC)) u_sel (
        .req       (en_req),
        .prio      (prio),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    assign accept = boundary_i && !reti_i && ie_i[7] && win_valid &&
                    (!cur_valid || win_prio > cur_lvl);

    irq_level_track u_lvl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_lvl  (win_prio),
        .pop       (reti_i),
        .active    (active),
        .cur_valid (cur_valid),
        .cur_lvl   (cur_lvl)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o     <= 1'b0;
            vector_o   <= '0;
            ack_src_o  <= '0;
            clr_ext0_o <= 1'b0;
        end else begin
            take_o     <= accept;
            clr_ext0_o <= accept && (win_idx == '0) && ext0_edge_i;
            if (accept) begin
                vector_o  <= entry_addr(win_idx);
                ack_src_o <= win_idx;
            end
        end
    end

    assign active_o    = active;
    assign cur_valid_o = cur_valid;
    assign cur_lvl_o   = cur_lvl;
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       boundary_i,
    input logic       reti_i,
    input logic [7:0] ie_i,
    input logic       take_o,
    input logic [7:0] vector_o,
    input logic [2:0] ack_src_o,
    input logic       clr_ext0_o,
    input logic [3:0] active_o,
    input logic       cur_valid_o,
    input logic [1:0] cur_lvl_o
);
    p_gate_ea_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(ie_i[7]));

    p_src_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (($past(ie_i) >> ack_src_o) & 8'h01) == 8'h01);

    p_vec_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (vector_o[2:0] == 3'b011 && vector_o[7:6] == 2'b00 && vector_o[5:3] <= 3'd5));

    p_strict_preempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && $past(cur_valid_o)) |-> cur_lvl_o > $past(cur_lvl_o));

    p_mask_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ($countones(active_o) == $countones($past(active_o)) + 1 && cur_valid_o));

    p_pop_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reti_i) && $past(cur_valid_o)) |->
            $countones(active_o) + 1 == $countones($past(active_o)));

    p_no_take_on_reti_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !$past(reti_i));

    p_clr_only_src0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ext0_o |-> (take_o && ack_src_o == 3'd0));

    p_boundary_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(boundary_i));

    p_valid_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cur_valid_o == (active_o != 4'b0000));
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .boundary_i  (boundary_i),
    .reti_i      (reti_i),
    .ie_i        (ie_i),
    .take_o      (take_o),
    .vector_o    (vector_o),
    .ack_src_o   (ack_src_o),
    .clr_ext0_o  (clr_ext0_o),
    .active_o    (active_o),
    .cur_valid_o (cur_valid_o),
    .cur_lvl_o   (cur_lvl_o)
);

// File: tb/irq_nest_ctrl_tb.sv
module irq_nest_ctrl_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic       rst_n = 1'b0, boundary = 1'b0, reti = 1'b0;
    logic       ext0 = 0, ext0_edge = 0, t0 = 0, ext1 = 0, t1 = 0;
    logic       srx = 0, stx = 0, t2o = 0, t2e = 0;
    logic [7:0] ie = 8'h00, wdata = 8'h00;
    logic       plo_we = 0, phi_we = 0;

    logic       take, clr0, cval, take_n, clr0_n, cval_n;
    logic [7:0] vec, vec_n;
    logic [2:0] src, src_n;
    logic [3:0] act, act_n;
    logic [1:0] lvl, lvl_n;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    irq_nest_ctrl #(.HAS_T2(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .reti_i(reti),
        .ext0_flag_i(ext0), .ext0_edge_i(ext0_edge), .t0_ovf_i(t0),
        .ext1_flag_i(ext1), .t1_ovf_i(t1), .ser_rx_i(srx), .ser_tx_i(stx),
        .t2_ovf_i(t2o), .t2_ext_i(t2e), .ie_i(ie), .plo_we_i(plo_we),
        .phi_we_i(phi_we), .wdata_i(wdata), .take_o(take), .vector_o(vec),
        .ack_src_o(src), .clr_ext0_o(clr0), .active_o(act),
        .cur_valid_o(cval), .cur_lvl_o(lvl));

    irq_nest_ctrl #(.HAS_T2(1'b0)) dut_nt2 (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .reti_i(reti),
        .ext0_flag_i(ext0), .ext0_edge_i(ext0_edge), .t0_ovf_i(t0),
        .ext1_flag_i(ext1), .t1_ovf_i(t1), .ser_rx_i(srx), .ser_tx_i(stx),
        .t2_ovf_i(t2o), .t2_ext_i(t2e), .ie_i(ie), .plo_we_i(plo_we),
        .phi_we_i(phi_we), .wdata_i(wdata), .take_o(take_n), .vector_o(vec_n),
        .ack_src_o(src_n), .clr_ext0_o(clr0_n), .active_o(act_n),
        .cur_valid_o(cval_n), .cur_lvl_o(lvl_n));

    // {lo[8], hi[8], ie[8], req[6] (bit5 = t2_ovf, bit4 = ser_rx), take, src[3]}
    localparam int NV = 10;
    localparam logic [33:0] VEC [NV] = '{
        {8'h00, 8'h00, 8'hBF, 6'b111111, 1'b1, 3'd0},  // R5 tie at level 0
        {8'h00, 8'h00, 8'h3F, 6'b111111, 1'b0, 3'd0},  // R2 global off
        {8'h00, 8'h00, 8'hBE, 6'b000001, 1'b0, 3'd0},  // R3 source masked
        {8'h08, 8'h00, 8'hBF, 6'b001111, 1'b1, 3'd3},  // R4 low bit raises src3
        {8'h08, 8'h04, 8'hBF, 6'b001111, 1'b1, 3'd2},  // R4 high bit beats low bit
        {8'h30, 8'h30, 8'hBF, 6'b111111, 1'b1, 3'd4},  // R5 tie at level 3
        {8'h20, 8'h20, 8'hBF, 6'b110000, 1'b1, 3'd5},  // R4 src5 top
        {8'h00, 8'h02, 8'hBF, 6'b000011, 1'b1, 3'd1},  // R4 src1 level 2
        {8'h3F, 8'h3F, 8'hBF, 6'b101000, 1'b1, 3'd3},  // R5 tie, lower index
        {8'h00, 8'h00, 8'h80, 6'b111111, 1'b0, 3'd0}   // R3 all masked
    };

    task automatic check(input string req, input int actual, input int expected);
        n_chk++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {ext0, t0, ext1, t1, srx, stx, t2o, t2e, boundary, reti} = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_prio(input logic [7:0] lo, input logic [7:0] hi);
        @(negedge clk); plo_we = 1; wdata = lo;
        @(negedge clk); plo_we = 0; phi_we = 1; wdata = hi;
        @(negedge clk); phi_we = 0;
    endtask

    // Strobe one boundary; outputs are sampled on the following negedge.
    task automatic strobe(input logic with_reti);
        @(negedge clk); boundary = 1; reti = with_reti;
        @(negedge clk); boundary = 0; reti = 0;
    endtask

    task automatic do_reti();
        @(negedge clk); reti = 1;
        @(negedge clk); reti = 0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 take", take, 0);
        check("R1 active", act, 0);
        check("R1 cur_valid", cval, 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            logic [33:0] e;
            e = VEC[v];
            do_reset();
            wr_prio(e[33:26], e[25:18]);
            ie = e[17:10];
            {t2o, srx, t1, ext1, t0, ext0} = e[9:4];
            strobe(0);
            check("R2/R3/R4/R5 take", take, e[3]);
            if (e[3]) begin
                check("R8 ack_src", src, e[2:0]);
                check("R6 vector", vec, e[2:0] * 8 + 3);
            end
        end

        // R12: no boundary, no acceptance; R1 priorities zero gives src0
        do_reset();
        ie = 8'hBF; ext0 = 1; t0 = 1;
        repeat (4) @(negedge clk);
        check("R12 no strobe", take, 0);
        strobe(0);
        check("R1 reset prio tie", src, 0);
        @(negedge clk);
        check("R8 take one cycle", take, 0);

        // Nesting walk: src0 lvl1, src1 lvl2, src2 lvl0, src3 lvl3
        do_reset();
        wr_prio(8'h09, 8'h0A);
        ie = 8'hBF;
        ext1 = 1; strobe(0);
        check("R8 take src2", take, 1);
        check("R8 active", act, 4'b0001);
        check("R8 level", lvl, 0);
        strobe(0);
        check("R7 equal held", take, 0);
        ext1 = 0;
        ext0 = 1; strobe(0);
        check("R7 higher taken", take, 1);
        check("R8 active nest", act, 4'b0011);
        check("R8 level nest", lvl, 1);
        ext0 = 0;
        t1 = 1; strobe(0);
        check("R8 take src3", src, 3);
        check("R8 active lvl3", act, 4'b1011);
        check("R8 level 3", lvl, 3);
        t1 = 0;
        t0 = 1; strobe(0);
        check("R7 lower held", take, 0);
        do_reti();
        check("R9 unwind mask", act, 4'b0011);
        check("R9 unwind level", lvl, 1);
        strobe(0);
        check("R7 preempt after pop", src, 1);
        check("R9 active", act, 4'b0111);
        t0 = 0;
        t1 = 1; strobe(1);
        check("R9 reti blocks take", take, 0);
        check("R9 reti with strobe", act, 4'b0011);
        t1 = 0;
        do_reti();
        check("R9 pop to lvl0", lvl, 0);
        do_reti();
        check("R9 empty", act, 0);
        check("R9 none", cval, 0);
        do_reti();
        check("R9 reti on empty", act, 0);

        // R10 clear pulse only in edge mode
        do_reset();
        ie = 8'hBF; ext0 = 1; ext0_edge = 1;
        strobe(0);
        check("R10 edge clear", clr0, 1);
        do_reset();
        ie = 8'hBF; ext0 = 1; ext0_edge = 0;
        strobe(0);
        check("R10 level keeps", clr0, 0);
        check("R10 take anyway", take, 1);

        // R11 serial tx alone, timer2 ext alone, no-T2 variant
        do_reset();
        ie = 8'hBF; stx = 1;
        strobe(0);
        check("R11 serial tx", vec, 8'h23);
        do_reset();
        ie = 8'hBF; t2e = 1;
        strobe(0);
        check("R11 t2 ext", vec, 8'h2B);
        check("R11 no t2 variant", take_n, 0);

        summary();
    end
endmodule